// File: doc/BRIEF.md
# Asynchronous Serial Receiver/Transmitter with Fractional Stop Time

This block is a full-duplex asynchronous serial port. The transmitter turns one parallel character into a frame on `txd`. The frame is a low start bit, then 5 to 8 data bits, then an optional parity bit, then a marking stop time. The stop time is set in sixteenths of a bit. The receiver watches `rxd` and rebuilds characters. Each character is delivered together with its parity-error, framing-error and compare-match flags. Both directions advance on a shared clock enable, `tick`. This enable runs at sixteen times the bit rate or at the bit rate itself. The rate is generated outside the block.

Characters enter on a valid/ready pair. The transmitter raises `tx_ready` only while it is idle, enabled and not sending a break, so a writer simply holds `tx_valid` until it sees the handshake. The receiver holds one finished character on `rx_valid` and keeps it, with `rx_data` and its flags, stable until `rx_ready` is sampled high. If another character finishes while that slot is still occupied, the new character is lost and `rx_overrun` pulses. Back-pressure on the receive side therefore never stalls the serial line.

The receiver also recognises a line held at space. It delivers one zero character and marks the start and end of the break with pulses. A local loopback mode routes the transmitter into the receiver and keeps the pin at mark.

Top module: `async_serial_port`

## Requirements
- R1: `cfg_len` selects the character length: 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. Data bits go out and come in least significant bit first. Transmit data bits above the length are not sent, and received bits above the length read as zero.
- R2: With `cfg_par_en` high, a parity bit follows the last data bit. `cfg_par_kind` selects it: 0 makes the count of ones even, 1 makes it odd, 2 forces the bit low and 3 forces it high. A received parity bit that differs from this value sets `rx_perr` on that character.
- R3: In 16X mode the transmitted stop time lasts `cfg_stop`+1 ticks, which is 1/16 to 2 bits. In 1X mode it lasts one bit when `cfg_stop` is below 16 and two bits otherwise. With back-to-back characters, the marking gap equals the stop time plus one clock.
- R4: `cfg_x16`=1 makes every bit 16 ticks long, and `cfg_x16`=0 makes every bit one tick long, in both directions.
- R5: A received stop bit sampled low sets `rx_ferr` on that character.
- R6: A character that completes while `rx_valid` is high and `rx_ready` is low is discarded, and `rx_overrun` pulses for one clock. The held character and its flags stay unchanged until they are accepted.
- R7: In 16X mode the receiver samples a start bit again at sample 8, counting the first low sample as sample 0. If the line is high there, the start is discarded and no character is delivered.
- R8: A received frame whose data, parity and stop bits are all low is delivered as one character of value 0 with `rx_ferr`=1 and `rx_perr`=0, and `brk_begin` pulses with it. No further character is delivered until the line is sampled high at a tick, which pulses `brk_done`.
- R9: `txd` stays high while `tx_en` is low or `loopback` is high. `tx_ready` is low while `tx_en` is low. In loopback the receiver takes the transmitter output in place of `rxd`.
- R10: `rx_match` is set on a received character when `cfg_cmp_en` is high and the data equal `cfg_cmp` limited to the character length.
- R11: `brk_send` asserted while the transmitter is idle drives `txd` low and holds `tx_ready` low. When `brk_send` is released, the line returns to mark.
- R12: The start bit appears on `txd` in the clock after a `tx_valid`/`tx_ready` handshake.
- R13: In 16X mode each received data bit is sampled once, at sample 8 of its 16. Disturbances confined to the outer samples of a bit do not change the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bit-clock enable (16X or 1X of the bit rate) |
| cfg_x16 | input | 1 | 1: 16 ticks per bit, 0: 1 tick per bit |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_kind | input | 2 | 0 even, 1 odd, 2 forced low, 3 forced high |
| cfg_stop | input | 5 | Stop time code in sixteenths of a bit, minus one |
| cfg_cmp_en | input | 1 | Enable character compare |
| cfg_cmp | input | 8 | Compare value |
| tx_en | input | 1 | Transmitter enable |
| loopback | input | 1 | Internal loop from transmitter to receiver |
| brk_send | input | 1 | Hold the line at space |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Transmitter accepts a character |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Received character held |
| rx_ready | input | 1 | Consumer accepts the character |
| rx_perr | output | 1 | Parity error on held character |
| rx_ferr | output | 1 | Framing error on held character |
| rx_match | output | 1 | Held character equals compare value |
| rx_overrun | output | 1 | One-clock pulse: character lost |
| brk_begin | output | 1 | One-clock pulse: break received |
| brk_done | output | 1 | One-clock pulse: break ended |

## Verification
The start bit is due on `txd` exactly one clock after the transmit handshake. Every following bit lasts 16 ticks, or one tick in 1X mode. The bench therefore finds the falling edge of the start bit and samples each bit at its centre, 8 and then 16 clocks further on. A received character reaches `rx_valid` two synchroniser clocks after the middle of its stop bit, so receive checks wait in a bounded window for the handshake and compare the captured values. The pulses `brk_begin`, `brk_done` and `rx_overrun` are counted on every clock and compared at fixed points after the line events that cause them. Stop-time checks measure the marking run between two back-to-back frames in clocks, with `tick` held high.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int MAXDW = 8;

  typedef enum logic [1:0] {
    PK_EVEN   = 2'd0,
    PK_ODD    = 2'd1,
    PK_FORCE0 = 2'd2,
    PK_FORCE1 = 2'd3
  } par_kind_t;

  typedef enum logic [2:0] {
    FS_IDLE, FS_START, FS_DATA, FS_PAR, FS_STOP, FS_BRK
  } fstate_t;

  // mask of the active data bits for a length code (0 -> 5 bits ... 3 -> 8 bits)
  function automatic logic [MAXDW-1:0] len_mask(input logic [1:0] len);
    return {MAXDW{1'b1}} >> (2'd3 - len);
  endfunction

  function automatic logic par_calc(input logic [MAXDW-1:0] d,
                                    input logic [1:0] len,
                                    input logic [1:0] kind);
    logic [MAXDW-1:0] m;
    m = d & len_mask(len);
    case (par_kind_t'(kind))
      PK_EVEN:   return ^m;
      PK_ODD:    return ~^m;
      PK_FORCE0: return 1'b0;
      default:   return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/sport_tx.sv
module sport_tx import sport_pkg::*; #(
  parameter int OVS    = 16,
  parameter int STOP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             x16,
  input  logic             en,
  input  logic             brk_req,
  input  logic [1:0]       len,
  input  logic             par_en,
  input  logic [1:0]       par_kind,
  input  logic [STOP_W-1:0] stop_m1,
  input  logic [MAXDW-1:0] data,
  input  logic             valid,
  output logic             ready,
  output logic             line
);
  localparam int CW = $clog2(OVS);
  localparam int TW = (STOP_W > CW) ? STOP_W : CW;

  fstate_t          st;
  logic [TW-1:0]    tcnt;
  logic [MAXDW-1:0] shreg;
  logic [2:0]       bidx;
  logic             par_r;
  logic [TW-1:0]    bit_last, stop_last;
  logic [2:0]       nb_m1;
  logic             bit_end;

  assign bit_last  = x16 ? TW'(OVS-1) : '0;
  assign stop_last = x16 ? TW'(stop_m1) : ((int'(stop_m1) < OVS) ? TW'(0) : TW'(1));
  assign nb_m1     = 3'd4 + {1'b0, len};
  assign bit_end   = tick && (tcnt == bit_last);
  assign ready     = en && !brk_req && (st == FS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FS_IDLE; line <= 1'b1; tcnt <= '0;
      shreg <= '0; bidx <= '0; par_r <= 1'b0;
    end else if (!en) begin
      st <= FS_IDLE; line <= 1'b1; tcnt <= '0;
    end else begin
      case (st)
        FS_IDLE: begin
          line <= 1'b1;
          tcnt <= '0;
          if (brk_req) begin
            st <= FS_BRK; line <= 1'b0;
          end else if (valid) begin
            st    <= FS_START;
            line  <= 1'b0;
            shreg <= data;
            bidx  <= '0;
            par_r <= par_calc(data, len, par_kind);
          end
        end
        FS_BRK: begin
          if (!brk_req) begin st <= FS_IDLE; line <= 1'b1; end
        end
        FS_START, FS_DATA, FS_PAR: begin
          if (bit_end) begin
            tcnt <= '0;
            if (st == FS_START || (st == FS_DATA && bidx != nb_m1)) begin
              st    <= FS_DATA;
              line  <= shreg[0];
              shreg <= shreg >> 1;
              bidx  <= (st == FS_START) ? 3'd0 : 3'(bidx + 3'd1);
            end else if (st == FS_DATA && par_en) begin
              st <= FS_PAR; line <= par_r;
            end else begin
              st <= FS_STOP; line <= 1'b1;
            end
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        FS_STOP: begin
          if (tick) begin
            if (tcnt == stop_last) st <= FS_IDLE;
            else tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx import sport_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             x16,
  input  logic             line,
  input  logic [1:0]       len,
  input  logic             par_en,
  input  logic [1:0]       par_kind,
  input  logic             cmp_en,
  input  logic [MAXDW-1:0] cmp_val,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [MAXDW-1:0] out_data,
  output logic             out_perr,
  output logic             out_ferr,
  output logic             out_match,
  output logic             ovr,
  output logic             brk_start,
  output logic             brk_end
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  fstate_t          st;
  logic [CW-1:0]    cnt;
  logic [2:0]       bidx;
  logic [MAXDW-1:0] dbuf;
  logic             pr;
  logic [CW-1:0]    bit_last;
  logic [2:0]       nb_m1;
  logic             samp;
  logic             is_brk, perr_c, match_c;

  assign bit_last = x16 ? CW'(OVS-1) : '0;
  assign nb_m1    = 3'd4 + {1'b0, len};
  assign samp     = tick && (cnt == bit_last);

  // evaluated at the stop sample
  always_comb begin
    is_brk  = (dbuf == '0) && !line && !(par_en && pr);
    perr_c  = par_en && (pr != par_calc(dbuf, len, par_kind)) && !is_brk;
    match_c = cmp_en && (dbuf == (cmp_val & len_mask(len)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= FS_IDLE; cnt <= '0; bidx <= '0; dbuf <= '0; pr <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_perr <= 1'b0;
      out_ferr <= 1'b0; out_match <= 1'b0;
      ovr <= 1'b0; brk_start <= 1'b0; brk_end <= 1'b0;
    end else begin
      ovr <= 1'b0; brk_start <= 1'b0; brk_end <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (tick) begin
        case (st)
          FS_IDLE: if (!line) begin
            cnt <= '0; bidx <= '0; dbuf <= '0;
            st  <= x16 ? FS_START : FS_DATA;
          end
          FS_START: begin
            if (cnt == CW'(HALF-1)) begin
              cnt <= '0;
              st  <= line ? FS_IDLE : FS_DATA;
            end else cnt <= cnt + 1'b1;
          end
          FS_DATA: begin
            if (samp) begin
              cnt        <= '0;
              dbuf[bidx] <= line;
              if (bidx == nb_m1) st <= par_en ? FS_PAR : FS_STOP;
              else bidx <= 3'(bidx + 3'd1);
            end else cnt <= cnt + 1'b1;
          end
          FS_PAR: begin
            if (samp) begin cnt <= '0; pr <= line; st <= FS_STOP; end
            else cnt <= cnt + 1'b1;
          end
          FS_STOP: begin
            if (samp) begin
              cnt <= '0;
              st  <= is_brk ? FS_BRK : FS_IDLE;
              brk_start <= is_brk;
              if (out_valid && !out_ready) begin
                ovr <= 1'b1;
              end else begin
                out_valid <= 1'b1;
                out_data  <= dbuf;
                out_perr  <= perr_c;
                out_ferr  <= !line;
                out_match <= match_c;
              end
            end else cnt <= cnt + 1'b1;
          end
          FS_BRK: if (line) begin st <= FS_IDLE; brk_end <= 1'b1; end
          default: st <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port import sport_pkg::*; #(
  parameter int OVS    = 16,
  parameter int STOP_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_x16,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic [1:0]       cfg_par_kind,
  input  logic [STOP_W-1:0] cfg_stop,
  input  logic             cfg_cmp_en,
  input  logic [MAXDW-1:0] cfg_cmp,
  input  logic             tx_en,
  input  logic             loopback,
  input  logic             brk_send,
  input  logic [MAXDW-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             rxd,
  output logic [MAXDW-1:0] rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_match,
  output logic             rx_overrun,
  output logic             brk_begin,
  output logic             brk_done
);
  logic              tx_line;
  logic              rx_src;
  logic [SYNC_N-1:0] sync_q;

  assign rx_src = loopback ? tx_line : rxd;
  assign txd    = (tx_en && !loopback) ? tx_line : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_N-2:0], rx_src};
  end

  sport_tx #(.OVS(OVS), .STOP_W(STOP_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .x16(cfg_x16), .en(tx_en),
    .brk_req(brk_send), .len(cfg_len), .par_en(cfg_par_en),
    .par_kind(cfg_par_kind), .stop_m1(cfg_stop), .data(tx_data),
    .valid(tx_valid), .ready(tx_ready), .line(tx_line)
  );

  sport_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .x16(cfg_x16),
    .line(sync_q[SYNC_N-1]), .len(cfg_len), .par_en(cfg_par_en),
    .par_kind(cfg_par_kind), .cmp_en(cfg_cmp_en), .cmp_val(cfg_cmp),
    .out_ready(rx_ready), .out_valid(rx_valid), .out_data(rx_data),
    .out_perr(rx_perr), .out_ferr(rx_ferr), .out_match(rx_match),
    .ovr(rx_overrun), .brk_start(brk_begin), .brk_end(brk_done)
  );
endmodule

// File: rtl/async_serial_port_chk.sv
module async_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       loopback,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rx_ferr,
  input logic       rx_overrun,
  input logic       brk_begin,
  input logic       brk_done
);
  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  // R6
  ovr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_valid);
  // R8
  brk_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_begin |-> rx_overrun || (rx_valid && rx_ferr && rx_data == 8'h00));
  // R8
  brk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_begin, brk_done}));
  // R12
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_en && !loopback |=> !txd);
  // R9
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_ready);
endmodule

bind async_serial_port async_serial_port_chk u_chk (.*);

// File: tb/async_serial_port_bench.sv
module async_serial_port_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_x16 = 1'b1, cfg_par_en = 1'b0, cfg_cmp_en = 1'b0;
  logic [1:0] cfg_len = 2'd3, cfg_par_kind = 2'd0;
  logic [4:0] cfg_stop = 5'd15;
  logic [7:0] cfg_cmp = 8'h00, tx_data = 8'h00;
  logic tx_en = 1'b1, loopback = 1'b0, brk_send = 1'b0, tx_valid = 1'b0;
  logic rx_ready = 1'b1, drv = 1'b1, rx_sel = 1'b0;
  logic tx_ready, txd, rx_valid, rx_perr, rx_ferr, rx_match, rx_overrun, brk_begin, brk_done;
  logic [7:0] rx_data;
  wire rxd = rx_sel ? txd : drv;

  always #(CLK_P/2) clk = ~clk;

  async_serial_port u_async_serial_port (
    .clk(clk), .rst_n(rst_n), .tick(1'b1), .cfg_x16(cfg_x16), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_kind(cfg_par_kind), .cfg_stop(cfg_stop),
    .cfg_cmp_en(cfg_cmp_en), .cfg_cmp(cfg_cmp), .tx_en(tx_en), .loopback(loopback),
    .brk_send(brk_send), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_match(rx_match), .rx_overrun(rx_overrun),
    .brk_begin(brk_begin), .brk_done(brk_done)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int got_n = 0, n_ovr = 0, n_bs = 0, n_be = 0, low_cnt = 0, run_hi = 0, last_run = 0;
  logic [7:0] got_d [64];
  logic got_p [64], got_f [64], got_m [64];
  logic [11:0] cap;

  // observation of the ports, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && rx_ready && got_n < 64) begin
        got_d[got_n] = rx_data; got_p[got_n] = rx_perr;
        got_f[got_n] = rx_ferr; got_m[got_n] = rx_match; got_n++;
      end
      if (rx_overrun) n_ovr++;
      if (brk_begin) n_bs++;
      if (brk_done) n_be++;
      if (!txd) low_cnt++;
      if (txd) run_hi++;
      else begin if (run_hi > 0) last_run = run_hi; run_hi = 0; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] msk(input logic [1:0] len);
    return 8'hFF >> (3 - len);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] len, input logic [1:0] k);
    int ones = 0;
    for (int i = 0; i < 8; i++) if (i < 5 + len && d[i]) ones++;
    case (k)
      2'd0: return logic'(ones % 2);
      2'd1: return logic'(1 - ones % 2);
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic do_tx(input logic [7:0] d);
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic capture(input int nb);
    int half, step;
    half = cfg_x16 ? 8 : 0;
    step = cfg_x16 ? 16 : 1;
    cap = '0;
    @(negedge clk);
    while (txd) @(negedge clk);
    repeat (half) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (step) @(negedge clk);
      cap[i] = txd;
    end
  endtask

  task automatic drive_bit(input logic v, input bit glitch, input int ncyc);
    for (int k = 0; k < ncyc; k++) begin
      drv = (glitch && (k < 3 || k > 12)) ? ~v : v;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pen, input logic pb,
                            input logic stopv, input int stoplen, input bit glitch);
    drive_bit(1'b0, 0, 16);
    for (int i = 0; i < nb; i++) drive_bit(d[i], glitch, 16);
    if (pen) drive_bit(pb, 0, 16);
    drive_bit(stopv, 0, stoplen);
    drv = 1'b1;
  endtask

  task automatic wait_rx(input int base, input int lim);
    for (int k = 0; k < lim && got_n <= base; k++) @(negedge clk);
  endtask

  // x16, len, par_en, kind, stop, data, cmp_en, cmp
  localparam logic [27:0] VEC [8] = '{
    {1'b1, 2'd3, 1'b0, 2'd0, 5'd15, 8'hA5, 1'b1, 8'hA5},
    {1'b1, 2'd2, 1'b1, 2'd0, 5'd15, 8'h53, 1'b0, 8'h53},
    {1'b1, 2'd0, 1'b1, 2'd1, 5'd7,  8'hFE, 1'b1, 8'h3E},
    {1'b1, 2'd1, 1'b1, 2'd2, 5'd23, 8'h2D, 1'b0, 8'h00},
    {1'b1, 2'd3, 1'b1, 2'd3, 5'd31, 8'h00, 1'b1, 8'h01},
    {1'b0, 2'd3, 1'b1, 2'd0, 5'd15, 8'hC3, 1'b0, 8'h00},
    {1'b0, 2'd1, 1'b1, 2'd1, 5'd16, 8'h15, 1'b1, 8'h16},
    {1'b1, 2'd3, 1'b1, 2'd1, 5'd0,  8'h7F, 1'b1, 8'h7F}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, nb, o0;
    logic [7:0] d, ed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset txd", txd, 1);
    chk("R12 reset tx_ready", tx_ready, 1);
    chk("R6 reset rx_valid", rx_valid, 0);

    // table: transmit, capture the wire, receive it back
    rx_sel = 1'b1;
    for (int i = 0; i < 8; i++) begin
      {cfg_x16, cfg_len, cfg_par_en, cfg_par_kind, cfg_stop, d, cfg_cmp_en, cfg_cmp} = VEC[i];
      @(negedge clk);
      nb = 5 + cfg_len;
      ed = d & msk(cfg_len);
      base = got_n;
      fork
        do_tx(d);
        capture(nb + (cfg_par_en ? 1 : 0));
      join
      chk($sformatf("R1/R4 vec%0d wire data", i), cap & 12'(msk(cfg_len)), 32'(ed));
      if (cfg_par_en) chk($sformatf("R2 vec%0d wire parity", i), cap[nb], exp_par(d, cfg_len, cfg_par_kind));
      wait_rx(base, 600);
      chk($sformatf("R1 vec%0d rx count", i), got_n, base + 1);
      chk($sformatf("R13 vec%0d rx data", i), got_d[base], ed);
      chk($sformatf("R2 vec%0d rx perr", i), got_p[base], 0);
      chk($sformatf("R5 vec%0d rx ferr", i), got_f[base], 0);
      chk($sformatf("R10 vec%0d match", i), got_m[base],
          cfg_cmp_en && (ed == (cfg_cmp & msk(cfg_len))));
      repeat (40) @(negedge clk);
    end
    rx_sel = 1'b0; drv = 1'b1;
    cfg_cmp_en = 1'b0;

    // R3 / R12: stop gap in 16X
    cfg_x16 = 1; cfg_len = 3; cfg_par_en = 0;
    for (int s = 0; s < 2; s++) begin
      cfg_stop = (s == 0) ? 5'd7 : 5'd27;
      @(negedge clk);
      do_tx(8'h00);
      chk("R12 start one clock after handshake", txd, 0);
      do_tx(8'h00);
      repeat (2) @(negedge clk);
      chk("R3 16X stop gap", last_run, cfg_stop + 2);
      while (!tx_ready) @(negedge clk);
    end
    // R3 in 1X
    cfg_x16 = 0;
    for (int s = 0; s < 2; s++) begin
      cfg_stop = (s == 0) ? 5'd5 : 5'd20;
      @(negedge clk);
      do_tx(8'h00);
      do_tx(8'h00);
      repeat (2) @(negedge clk);
      chk("R3 1X stop gap", last_run, (s == 0) ? 2 : 3);
      while (!tx_ready) @(negedge clk);
    end
    cfg_x16 = 1; cfg_stop = 5'd15;
    repeat (20) @(negedge clk);

    // R2 parity error
    cfg_par_en = 1; cfg_par_kind = 0;
    base = got_n;
    send_frame(8'h35, 8, 1, 1'b1, 1'b1, 16, 0);
    wait_rx(base, 100);
    chk("R2 perr data", got_d[base], 8'h35);
    chk("R2 perr flag", got_p[base], 1);
    chk("R5 no ferr", got_f[base], 0);

    // R5 framing error
    cfg_par_en = 0;
    base = got_n;
    send_frame(8'h55, 8, 0, 1'b0, 1'b0, 10, 0);
    wait_rx(base, 100);
    chk("R5 ferr flag", got_f[base], 1);
    chk("R5 ferr data", got_d[base], 8'h55);
    repeat (60) @(negedge clk);
    chk("R5 no extra char", got_n, base + 1);

    // R7 false start
    base = got_n;
    drive_bit(1'b0, 0, 5); drv = 1'b1;
    repeat (60) @(negedge clk);
    chk("R7 false start discarded", got_n, base);
    send_frame(8'h3C, 8, 0, 1'b0, 1'b1, 16, 0);
    wait_rx(base, 100);
    chk("R7 next char", got_d[base], 8'h3C);

    // R13 mid-bit sampling with edge disturbances
    base = got_n;
    send_frame(8'hB2, 8, 0, 1'b0, 1'b1, 16, 1);
    wait_rx(base, 100);
    chk("R13 glitched bits", got_d[base], 8'hB2);

    // R8 break receive
    cfg_par_en = 1; cfg_par_kind = 0;
    base = got_n; o0 = n_bs;
    drive_bit(1'b0, 0, 20 * 16);
    chk("R8 one char", got_n, base + 1);
    chk("R8 zero data", got_d[base], 8'h00);
    chk("R8 ferr", got_f[base], 1);
    chk("R8 perr", got_p[base], 0);
    chk("R8 begin pulse", n_bs, o0 + 1);
    chk("R8 no end yet", n_be, 0);
    drv = 1'b1;
    repeat (40) @(negedge clk);
    chk("R8 end pulse", n_be, 1);
    chk("R8 nothing more", got_n, base + 1);
    cfg_par_en = 0;

    // R6 overrun
    rx_ready = 1'b0;
    base = got_n; o0 = n_ovr;
    send_frame(8'h11, 8, 0, 1'b0, 1'b1, 16, 0);
    send_frame(8'h22, 8, 0, 1'b0, 1'b1, 16, 0);
    repeat (20) @(negedge clk);
    chk("R6 overrun pulse", n_ovr, o0 + 1);
    chk("R6 held valid", rx_valid, 1);
    chk("R6 held data", rx_data, 8'h11);
    rx_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 one delivered", got_n, base + 1);
    chk("R6 first kept", got_d[base], 8'h11);

    // R9 loopback
    loopback = 1'b1;
    @(negedge clk);
    base = got_n; low_cnt = 0;
    do_tx(8'h96);
    wait_rx(base, 400);
    chk("R9 loopback pin marking", low_cnt, 0);
    chk("R9 loopback data", got_d[base], 8'h96);
    loopback = 1'b0;
    repeat (40) @(negedge clk);

    // R9 transmitter disabled
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 disabled ready", tx_ready, 0);
    low_cnt = 0; tx_data = 8'h00; tx_valid = 1'b1;
    repeat (50) @(negedge clk);
    tx_valid = 1'b0;
    chk("R9 disabled pin marking", low_cnt, 0);
    tx_en = 1'b1;
    @(negedge clk);

    // R11 break send
    brk_send = 1'b1;
    @(negedge clk);
    chk("R11 break low", txd, 0);
    chk("R11 break not ready", tx_ready, 0);
    repeat (30) @(negedge clk);
    chk("R11 break held", txd, 0);
    brk_send = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 release mark", txd, 1);
    chk("R11 release ready", tx_ready, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule